// File: doc/BRIEF.md
# Single-Register Load/Store Address Generator

This block sits in the memory stage of a 32-bit RISC core with sixteen architectural registers. For each single-register load or store it is given the base register value, a signed offset that was already shifted upstream, the register indices, the instruction's own address and a few control flags. From these it forms the access address and the store data. It runs one request/acknowledge exchange on a simple memory port. It returns the extended load data and the base-register update value together with its enable.

An operation starts with a one-cycle `start` pulse. The block then holds `busy` until it raises `done` for one cycle, and at that point the result outputs are valid. When the base or the destination is the program counter (index 15), the block substitutes prefetch-adjusted values. It also decides whether the base is written back, from the indexing mode and from whether the destination and base registers alias.

Top module: `lsu_agen_top`

## Requirements
- R1: When `base_idx` is 15, the base value used is `insn_addr + 8`, and `base_val` is ignored.
- R2: The effective address is the base plus the two's-complement `offset`, taken modulo 2^32.
- R3: With `pre_index`=1 the access uses the effective address. With `pre_index`=0 the access uses the unmodified base, and `wb_en` is 1 at `done` with `wb_val` equal to the effective address, whatever `wb_req` and the register indices are.
- R4: With `pre_index`=1, `wb_en` at `done` equals `wb_req` except when `dest_idx` equals `base_idx`, in which case it is 0. When enabled, `wb_val` is the effective address.
- R5: On a store, `mem_wdata` is `dest_val`, or `insn_addr + 12` when `dest_idx` is 15.
- R6: The size code `size` is decoded as 0 = word, 1 = unsigned byte, 2 = signed byte, 3 = unsigned halfword and 4 = signed halfword. `mem_size` is 0 for byte, 1 for halfword and 2 for word. A word store clears `mem_addr[1:0]`. All other accesses drive the address unchanged.
- R7: On a load, `load_data` is the word read from `mem_rdata`, or `mem_rdata` with bits [7:0] or [15:0] zero-extended (unsigned codes) or sign-extended (signed codes).
- R8: A store with a signed size code (2 or 4) issues no memory request. It raises `err` together with `done` on the cycle after `start`, with `wb_en`=0 and `flush`=0.
- R9: `done` rises one cycle after the acknowledged cycle for a store and two cycles after it for a load, and lasts one cycle. `flush` is 1 at `done` exactly when a load targets register 15.
- R10: `mem_req` rises the cycle after `start` and stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is high, then drops. A `start` received while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches an operation |
| base_idx | input | 4 | Base register index |
| dest_idx | input | 4 | Data register index (load target or store source) |
| base_val | input | 32 | Base register contents |
| dest_val | input | 32 | Data register contents for stores |
| insn_addr | input | 32 | Address of the executing instruction |
| offset | input | 32 | Signed offset from the shifter |
| pre_index | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| wb_req | input | 1 | Writeback requested by the instruction |
| is_load | input | 1 | 1 = load, 0 = store |
| size | input | 3 | Transfer size code (see R6) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_size | output | 2 | Memory access size |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, item in the low bits |
| done | output | 1 | Operation complete (one cycle) |
| load_data | output | 32 | Extended load data, valid at `done` |
| wb_en | output | 1 | Base writeback enable, valid at `done` |
| wb_val | output | 32 | Base writeback value |
| flush | output | 1 | Pipeline flush request at `done` |
| err | output | 1 | Invalid store size at `done` |

## Verification
The hardest case to reach from the ports is a second `start` that arrives while a request is still waiting for its acknowledge. Only this case shows whether the latched operation is protected. The bench holds `mem_ack` low for an extra cycle during one operation, pulses `start` with a different base value in that window, and then checks that the address on the bus and the writeback value still belong to the first operation. A similar deliberate pairing is needed for post-index writeback when the destination aliases the base, because that is the one case where the forcing rule and the suppression rule conflict.

// File: rtl/lsu_agen_pkg.sv
package lsu_agen_pkg;

    localparam int XLEN    = 32;
    localparam int IDX_W   = 4;
    localparam int PC_IDX  = 15;

    typedef enum logic [2:0] {
        SZ_WORD  = 3'd0,
        SZ_UBYTE = 3'd1,
        SZ_SBYTE = 3'd2,
        SZ_UHALF = 3'd3,
        SZ_SHALF = 3'd4
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_EXTRA = 2'd2,
        ST_DONE  = 2'd3
    } agen_state_e;

    typedef struct packed {
        agen_state_e       st;
        logic              we;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   wdata;
        logic [1:0]        msize;
        xfer_size_e        size;
        logic              wb_en;
        logic [XLEN-1:0]   wb_val;
        logic [XLEN-1:0]   ldata;
        logic              flush;
        logic              err;
    } agen_ctx_t;

endpackage

// File: rtl/lsu_addr_calc.sv
module lsu_addr_calc
    import lsu_agen_pkg::*;
#(
    parameter int XW       = XLEN,
    parameter int IW       = IDX_W,
    parameter int PC_REG   = PC_IDX,
    parameter int BASE_ADJ = 8
) (
    input  logic [IW-1:0] base_idx,
    input  logic [IW-1:0] dest_idx,
    input  logic [XW-1:0] base_val,
    input  logic [XW-1:0] insn_addr,
    input  logic [XW-1:0] offset,
    input  logic          pre_index,
    input  logic          wb_req,
    output logic [XW-1:0] acc_addr,
    output logic          wb_en,
    output logic [XW-1:0] wb_val
);
    localparam logic [IW-1:0] PC_SEL = IW'(PC_REG);
    localparam logic [XW-1:0] ADJ    = XW'(BASE_ADJ);

    logic [XW-1:0] base_eff;
    logic [XW-1:0] eff_addr;

    always_comb begin
        base_eff = (base_idx == PC_SEL) ? insn_addr + ADJ : base_val;
        eff_addr = base_eff + offset;
        acc_addr = pre_index ? eff_addr : base_eff;
        wb_val   = eff_addr;
        if (!pre_index) begin
            wb_en = 1'b1;
        end else begin
            wb_en = wb_req && (dest_idx != base_idx);
        end
    end
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt
    import lsu_agen_pkg::*;
#(
    parameter int XW        = XLEN,
    parameter int IW        = IDX_W,
    parameter int PC_REG    = PC_IDX,
    parameter int STORE_ADJ = 12,
    parameter int WORD_LSB  = 2
) (
    input  xfer_size_e    size,
    input  logic          is_load,
    input  logic [XW-1:0] acc_addr,
    input  logic [IW-1:0] dest_idx,
    input  logic [XW-1:0] dest_val,
    input  logic [XW-1:0] insn_addr,
    output logic [XW-1:0] bus_addr,
    output logic [XW-1:0] wdata,
    output logic [1:0]    msize,
    output logic          bad
);
    localparam logic [IW-1:0] PC_SEL = IW'(PC_REG);
    localparam logic [XW-1:0] ADJ    = XW'(STORE_ADJ);
    localparam logic [XW-1:0] ALIGN  = ~((XW'(1) << WORD_LSB) - XW'(1));

    logic signed_code;

    always_comb begin
        signed_code = (size == SZ_SBYTE) || (size == SZ_SHALF);
        bad         = !is_load && signed_code;
        wdata       = (dest_idx == PC_SEL) ? insn_addr + ADJ : dest_val;
        unique case (size)
            SZ_UBYTE, SZ_SBYTE: msize = 2'd0;
            SZ_UHALF, SZ_SHALF: msize = 2'd1;
            default:            msize = 2'd2;
        endcase
        if (!is_load && (size == SZ_WORD)) begin
            bus_addr = acc_addr & ALIGN;
        end else begin
            bus_addr = acc_addr;
        end
    end
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
    import lsu_agen_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int BW = 8,
    parameter int HW = 16
) (
    input  xfer_size_e    size,
    input  logic [XW-1:0] raw,
    output logic [XW-1:0] ext
);
    always_comb begin
        unique case (size)
            SZ_UBYTE: ext = {{(XW-BW){1'b0}}, raw[BW-1:0]};
            SZ_SBYTE: ext = {{(XW-BW){raw[BW-1]}}, raw[BW-1:0]};
            SZ_UHALF: ext = {{(XW-HW){1'b0}}, raw[HW-1:0]};
            SZ_SHALF: ext = {{(XW-HW){raw[HW-1]}}, raw[HW-1:0]};
            default:  ext = raw;
        endcase
    end
endmodule

// File: rtl/lsu_agen_top.sv
module lsu_agen_top
    import lsu_agen_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] base_idx,
    input  logic [IW-1:0] dest_idx,
    input  logic [XW-1:0] base_val,
    input  logic [XW-1:0] dest_val,
    input  logic [XW-1:0] insn_addr,
    input  logic [XW-1:0] offset,
    input  logic          pre_index,
    input  logic          wb_req,
    input  logic          is_load,
    input  logic [2:0]    size,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [XW-1:0] mem_addr,
    output logic [XW-1:0] mem_wdata,
    output logic [1:0]    mem_size,
    input  logic          mem_ack,
    input  logic [XW-1:0] mem_rdata,
    output logic          done,
    output logic [XW-1:0] load_data,
    output logic          wb_en,
    output logic [XW-1:0] wb_val,
    output logic          flush,
    output logic          err
);
    localparam logic [IW-1:0] PC_SEL = IW'(PC_IDX);

    agen_ctx_t  ctx_d, ctx_q;
    xfer_size_e size_in;

    logic [XW-1:0] acc_addr;
    logic          calc_wb_en;
    logic [XW-1:0] calc_wb_val;
    logic [XW-1:0] fmt_addr;
    logic [XW-1:0] fmt_wdata;
    logic [1:0]    fmt_msize;
    logic          fmt_bad;
    logic [XW-1:0] ext_data;

    assign size_in = xfer_size_e'(size);

    lsu_addr_calc #(.XW(XW), .IW(IW)) u_calc (
        .base_idx  (base_idx),
        .dest_idx  (dest_idx),
        .base_val  (base_val),
        .insn_addr (insn_addr),
        .offset    (offset),
        .pre_index (pre_index),
        .wb_req    (wb_req),
        .acc_addr  (acc_addr),
        .wb_en     (calc_wb_en),
        .wb_val    (calc_wb_val)
    );

    lsu_store_fmt #(.XW(XW), .IW(IW)) u_fmt (
        .size      (size_in),
        .is_load   (is_load),
        .acc_addr  (acc_addr),
        .dest_idx  (dest_idx),
        .dest_val  (dest_val),
        .insn_addr (insn_addr),
        .bus_addr  (fmt_addr),
        .wdata     (fmt_wdata),
        .msize     (fmt_msize),
        .bad       (fmt_bad)
    );

    lsu_load_ext #(.XW(XW)) u_ext (
        .size (ctx_q.size),
        .raw  (mem_rdata),
        .ext  (ext_data)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.we     = !is_load;
                    ctx_d.addr   = fmt_addr;
                    ctx_d.wdata  = fmt_wdata;
                    ctx_d.msize  = fmt_msize;
                    ctx_d.size   = size_in;
                    ctx_d.wb_val = calc_wb_val;
                    if (fmt_bad) begin
                        ctx_d.st    = ST_DONE;
                        ctx_d.err   = 1'b1;
                        ctx_d.wb_en = 1'b0;
                        ctx_d.flush = 1'b0;
                    end else begin
                        ctx_d.st    = ST_REQ;
                        ctx_d.err   = 1'b0;
                        ctx_d.wb_en = calc_wb_en;
                        ctx_d.flush = is_load && (dest_idx == PC_SEL);
                    end
                end
            end
            ST_REQ: begin
                if (mem_ack) begin
                    if (ctx_q.we) begin
                        ctx_d.st = ST_DONE;
                    end else begin
                        ctx_d.st    = ST_EXTRA;
                        ctx_d.ldata = ext_data;
                    end
                end
            end
            ST_EXTRA: ctx_d.st = ST_DONE;
            default:  ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, size: SZ_WORD, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        busy      = ctx_q.st != ST_IDLE;
        mem_req   = ctx_q.st == ST_REQ;
        mem_we    = ctx_q.we;
        mem_addr  = ctx_q.addr;
        mem_wdata = ctx_q.wdata;
        mem_size  = ctx_q.msize;
        done      = ctx_q.st == ST_DONE;
        load_data = ctx_q.ldata;
        wb_en     = done && ctx_q.wb_en;
        wb_val    = ctx_q.wb_val;
        flush     = done && ctx_q.flush;
        err       = done && ctx_q.err;
    end
endmodule

// File: rtl/lsu_agen_chk.sv
module lsu_agen_chk #(
    parameter int XW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [XW-1:0] mem_addr,
    input logic [XW-1:0] mem_wdata,
    input logic [1:0]    mem_size,
    input logic          done,
    input logic          err,
    input logic          wb_en,
    input logic          flush
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req); // R10
    AST_WORD_STORE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_size == 2'd2 |-> mem_addr[1:0] == 2'b00); // R6
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done && err |-> !wb_en && !flush); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FLUSH_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> done && !mem_we); // R9
endmodule

bind lsu_agen_top lsu_agen_chk #(.XW(XW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_size  (mem_size),
    .done      (done),
    .err       (err),
    .wb_en     (wb_en),
    .flush     (flush)
);

// File: tb/lsu_agen_top_bench.sv
module lsu_agen_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  base_idx = '0, dest_idx = '0;
    logic [31:0] base_val = '0, dest_val = '0, insn_addr = '0, offset = '0;
    logic        pre_index = 1'b0, wb_req = 1'b0, is_load = 1'b0;
    logic [2:0]  size = '0;
    logic        busy, mem_req, mem_we, done, wb_en, flush, err;
    logic [31:0] mem_addr, mem_wdata, load_data, wb_val;
    logic [1:0]  mem_size;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    bit          c_req;
    logic [31:0] c_addr, c_wdata, c_wbval, c_ldata;
    logic        c_we, c_wben, c_flush, c_err;
    logic [1:0]  c_msize;
    int          c_lat;
    bit          c_stable;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_agen_top u_lsu_agen_top (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_idx(base_idx), .dest_idx(dest_idx), .base_val(base_val),
        .dest_val(dest_val), .insn_addr(insn_addr), .offset(offset),
        .pre_index(pre_index), .wb_req(wb_req), .is_load(is_load), .size(size),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .load_data(load_data),
        .wb_en(wb_en), .wb_val(wb_val), .flush(flush), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Runs one operation; wait_cycles holds ack low, poke restarts while busy.
    task automatic do_op(input logic [3:0] bi, input logic [3:0] di,
                         input logic [31:0] bv, input logic [31:0] dv,
                         input logic [31:0] ia, input logic [31:0] off,
                         input logic pre, input logic wbr, input logic ld,
                         input logic [2:0] sz, input logic [31:0] rdata,
                         input int wait_cycles, input bit poke);
        c_req = 0; c_lat = -1; c_stable = 1;
        @(negedge clk);
        base_idx = bi; dest_idx = di; base_val = bv; dest_val = dv;
        insn_addr = ia; offset = off; pre_index = pre; wb_req = wbr;
        is_load = ld; size = sz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!done) begin
            for (int i = 0; i < 50 && !mem_req; i++) @(negedge clk);
            c_req = mem_req; c_addr = mem_addr; c_we = mem_we;
            c_wdata = mem_wdata; c_msize = mem_size;
            for (int i = 0; i < wait_cycles; i++) begin
                if (poke && i == 0) begin
                    start = 1'b1; base_val = bv + 32'h100; base_idx = 4'd1;
                end
                @(negedge clk);
                start = 1'b0;
                if (!mem_req || mem_addr !== c_addr) c_stable = 0;
            end
            mem_ack = 1'b1; mem_rdata = rdata;
            @(negedge clk);
            mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF;
            c_lat = 1;
            for (int i = 0; i < 20 && !done; i++) begin
                @(negedge clk);
                c_lat++;
            end
        end
        c_wben = wb_en; c_wbval = wb_val; c_ldata = load_data;
        c_flush = flush; c_err = err;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R10 reset busy", {31'd0, busy}, 32'd0);
        check("R10 reset req", {31'd0, mem_req}, 32'd0);
        check("R9 reset done", {31'd0, done}, 32'd0);
    endtask

    task automatic t_pre_load_word;
        do_op(4'd2, 4'd3, 32'h1000, 0, 32'h0, 32'h20, 1, 1, 1, 3'd0, 32'hCAFE_BABE, 0, 0);
        check("R3 pre addr", c_addr, 32'h1020);
        check("R10 load we", {31'd0, c_we}, 32'd0);
        check("R6 word msize", {30'd0, c_msize}, 32'd2);
        check("R4 wb_en", {31'd0, c_wben}, 32'd1);
        check("R4 wb_val", c_wbval, 32'h1020);
        check("R7 word data", c_ldata, 32'hCAFE_BABE);
        check("R9 load latency", c_lat, 2);
        check("R9 no flush", {31'd0, c_flush}, 32'd0);
    endtask

    task automatic t_post_store_word;
        do_op(4'd4, 4'd5, 32'h2003, 32'h1111_2222, 32'h0, 32'hFFFF_FFFC, 0, 0, 0, 3'd0, 0, 0, 0);
        check("R6 word store align", c_addr, 32'h2000);
        check("R5 store data", c_wdata, 32'h1111_2222);
        check("R3 post forced wb", {31'd0, c_wben}, 32'd1);
        check("R3 post wb_val", c_wbval, 32'h1FFF);
        check("R9 store latency", c_lat, 1);
    endtask

    task automatic t_wrap;
        do_op(4'd1, 4'd2, 32'hFFFF_FFF0, 0, 0, 32'h20, 1, 0, 1, 3'd0, 32'h5, 0, 0);
        check("R2 wrap addr", c_addr, 32'h10);
        check("R4 no wb_req", {31'd0, c_wben}, 32'd0);
    endtask

    task automatic t_pc_base;
        do_op(4'd15, 4'd3, 32'h9999_9999, 0, 32'h400, 32'h4, 1, 0, 1, 3'd1, 32'h1234_56F0, 0, 0);
        check("R1 pc base", c_addr, 32'h40C);
        check("R7 ubyte", c_ldata, 32'h0000_00F0);
        check("R6 byte msize", {30'd0, c_msize}, 32'd0);
    endtask

    task automatic t_extend;
        do_op(4'd1, 4'd2, 32'h100, 0, 0, 0, 1, 0, 1, 3'd2, 32'h0000_0180, 0, 0);
        check("R7 sbyte", c_ldata, 32'hFFFF_FF80);
        do_op(4'd1, 4'd2, 32'h100, 0, 0, 0, 1, 0, 1, 3'd4, 32'h1234_8001, 0, 0);
        check("R7 shalf", c_ldata, 32'hFFFF_8001);
        check("R6 half msize", {30'd0, c_msize}, 32'd1);
        do_op(4'd1, 4'd2, 32'h100, 0, 0, 0, 1, 0, 1, 3'd3, 32'h1234_8001, 0, 0);
        check("R7 uhalf", c_ldata, 32'h0000_8001);
        do_op(4'd1, 4'd2, 32'h100, 0, 0, 0, 1, 0, 1, 3'd2, 32'h0000_017F, 0, 0);
        check("R7 sbyte positive", c_ldata, 32'h0000_007F);
    endtask

    task automatic t_wb_alias;
        do_op(4'd6, 4'd6, 32'h500, 0, 0, 32'h8, 1, 1, 1, 3'd0, 0, 0, 0);
        check("R4 alias suppress", {31'd0, c_wben}, 32'd0);
        do_op(4'd6, 4'd6, 32'h500, 0, 0, 32'h8, 0, 0, 1, 3'd0, 0, 0, 0);
        check("R3 post alias addr", c_addr, 32'h500);
        check("R3 post alias wb", {31'd0, c_wben}, 32'd1);
        check("R3 post alias wb_val", c_wbval, 32'h508);
    endtask

    task automatic t_pc_store;
        do_op(4'd2, 4'd15, 32'h3001, 32'h7777_7777, 32'h800, 0, 1, 0, 0, 3'd3, 0, 0, 0);
        check("R5 pc store data", c_wdata, 32'h80C);
        check("R6 half store addr kept", c_addr, 32'h3001);
        check("R10 store we", {31'd0, c_we}, 32'd1);
    endtask

    task automatic t_err;
        do_op(4'd2, 4'd3, 32'h100, 0, 0, 0, 1, 1, 0, 3'd4, 0, 0, 0);
        check("R8 err shalf", {31'd0, c_err}, 32'd1);
        check("R8 no req", {31'd0, c_req}, 32'd0);
        check("R8 no wb", {31'd0, c_wben}, 32'd0);
        do_op(4'd2, 4'd3, 32'h100, 0, 0, 0, 1, 1, 0, 3'd2, 0, 0, 0);
        check("R8 err sbyte", {31'd0, c_err}, 32'd1);
    endtask

    task automatic t_flush;
        do_op(4'd2, 4'd15, 32'h100, 0, 0, 0, 1, 0, 1, 3'd0, 32'h40, 0, 0);
        check("R9 flush pc load", {31'd0, c_flush}, 32'd1);
        check("R9 no err", {31'd0, c_err}, 32'd0);
    endtask

    task automatic t_busy_ignore;
        do_op(4'd2, 4'd3, 32'h600, 0, 0, 32'h10, 1, 1, 1, 3'd0, 32'h1, 2, 1);
        check("R10 addr held", {31'd0, c_stable}, 32'd1);
        check("R10 addr first op", c_addr, 32'h610);
        check("R10 wb first op", c_wbval, 32'h610);
        check("R10 idle after", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pre_load_word();
        t_post_store_word();
        t_wrap();
        t_pc_base();
        t_extend();
        t_wb_alias();
        t_pc_store();
        t_err();
        t_flush();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule